// File: doc/BRIEF.md
# Two-Line Interrupt Flag Router

This block collects event pulses from a peripheral core into a bank of sticky interrupt flags and steers them onto two CPU interrupt lines. Each flag records a rising edge of its event input and holds it until software clears it by writing a one to that bit. The event sources themselves are outside the block.

Software reaches four registers through a simple write-strobe bus with a combinational read port. The flag register holds the sticky flags. The enable register decides which flags may raise an interrupt. The route register picks line 0 or line 1 for each flag. A two-bit gate register switches each output line on or off. Each output is a level signal that stays high while any enabled flag routed to it is pending and its gate bit is set.

Top module: `irq_router`

## Requirements
- R1: After reset, all four registers read as zero and both interrupt lines are low.
- R2: A flag is set only in the cycle its event input goes from 0 to 1. An event input that stays high does not set the flag again after the flag has been cleared. The event history resets to 0.
- R3: A set flag stays set over any number of cycles in which no clear of that bit takes place.
- R4: A write to address 0 clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R5: If a rising edge and a write-one-clear hit the same bit in the same cycle, the flag ends up set.
- R6: A pending flag drives a line only when its bit in the enable register (address 1) is 1.
- R7: The route register (address 2) steers each flag. A bit value of 0 sends the flag to line 0, and a value of 1 sends it to line 1.
- R8: Gate register bit 0 (address 3) gates line 0, and bit 1 gates line 1. Writes store only those two bits, and the upper read bits are 0.
- R9: A read of address 0 returns the raw flags, whatever the enable, route and gate settings are.
- R10: A read of address 1, 2 or 3 returns the last value written there. Writes to one address do not change the other registers.
- R11: Each line equals its gate bit ANDed with the OR of all flags that are pending, enabled and routed to that line. The line updates in the same cycle as the register change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| event_i | input | N_FLAGS | Event condition inputs from the core |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 flags, 1 enable, 2 route, 3 line gate |
| reg_wdata_i | input | N_FLAGS | Register write data |
| reg_rdata_o | output | N_FLAGS | Register read data for reg_addr_i |
| irq_line0_o | output | 1 | Interrupt line 0 |
| irq_line1_o | output | 1 | Interrupt line 1 |

## Verification
The bench holds an event input high across a write-one-clear. A level-sensitive design would set the flag again at once, while a correct one leaves it clear. It makes an edge and a clear of the same bit land in the same cycle, which catches a design where the clear wins. It sets a flag's route bit and sweeps the gate bits, which shows up a swapped route decode or an inverted gate. It then runs a long pseudo-random mix of events and writes against a model built from the requirements. That mix exposes write-zero side effects, writes leaking into the wrong register, and flags that read as masked.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Register map: the bus address selects one of four registers.
    typedef enum logic [1:0] {
        REG_FLAG    = 2'd0,
        REG_ENABLE  = 2'd1,
        REG_ROUTE   = 2'd2,
        REG_LINE_EN = 2'd3
    } reg_sel_e;

    // Number of CPU interrupt lines served by the router.
    localparam int NUM_LINES = 2;

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);

    typedef struct packed {
        logic [W-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A rise is the current level high while the sampled history is low.
    assign rise_o = level_i & ~st_q.prev;

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);

    typedef struct packed {
        logic [W-1:0] flags;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Clear is applied first, so a same-cycle set edge takes priority.
        st_d.flags = (st_q.flags & ~clr_i) | rise_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_route_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  reg_sel_e             addr_i,
    input  logic [W-1:0]         wdata_i,
    output logic [W-1:0]         enable_o,
    output logic [W-1:0]         route_o,
    output logic [NUM_LINES-1:0] line_en_o
);

    typedef struct packed {
        logic [W-1:0]         enable;
        logic [W-1:0]         route;
        logic [NUM_LINES-1:0] line_en;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (addr_i)
                REG_ENABLE:  st_d.enable  = wdata_i;
                REG_ROUTE:   st_d.route   = wdata_i;
                REG_LINE_EN: st_d.line_en = wdata_i[NUM_LINES-1:0];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable_o  = st_q.enable;
    assign route_o   = st_q.route;
    assign line_en_o = st_q.line_en;

endmodule

// File: rtl/irq_line_route.sv
module irq_line_route
    import irq_route_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]         flags_i,
    input  logic [W-1:0]         enable_i,
    input  logic [W-1:0]         route_i,
    input  logic [NUM_LINES-1:0] line_en_i,
    output logic [NUM_LINES-1:0] irq_o
);

    logic [W-1:0] armed;

    always_comb begin
        armed = flags_i & enable_i;
    end

    // One OR tree per line; the route bit picks membership.
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic [W-1:0] member;
        always_comb begin
            member = (l == 0) ? ~route_i : route_i;
        end
        assign irq_o[l] = line_en_i[l] & (|(armed & member));
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_route_pkg::*;
#(
    parameter int N_FLAGS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] event_i,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [N_FLAGS-1:0] reg_wdata_i,
    output logic [N_FLAGS-1:0] reg_rdata_o,
    output logic               irq_line0_o,
    output logic               irq_line1_o
);

    localparam int PAD_W = N_FLAGS - NUM_LINES;

    reg_sel_e               addr_sel;
    logic [N_FLAGS-1:0]     rise_vec;
    logic [N_FLAGS-1:0]     clr_vec;
    logic [N_FLAGS-1:0]     flag_vec;
    logic [N_FLAGS-1:0]     enable_vec;
    logic [N_FLAGS-1:0]     route_vec;
    logic [NUM_LINES-1:0]   line_en_vec;
    logic [NUM_LINES-1:0]   irq_vec;

    always_comb begin
        addr_sel = reg_sel_e'(reg_addr_i);
        clr_vec  = (reg_wr_i && addr_sel == REG_FLAG) ? reg_wdata_i : '0;
    end

    irq_edge_det #(.W(N_FLAGS)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (event_i),
        .rise_o  (rise_vec)
    );

    irq_flag_bank #(.W(N_FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise_vec),
        .clr_i   (clr_vec),
        .flags_o (flag_vec)
    );

    irq_cfg_regs #(.W(N_FLAGS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr_i),
        .addr_i    (addr_sel),
        .wdata_i   (reg_wdata_i),
        .enable_o  (enable_vec),
        .route_o   (route_vec),
        .line_en_o (line_en_vec)
    );

    irq_line_route #(.W(N_FLAGS)) u_route (
        .flags_i   (flag_vec),
        .enable_i  (enable_vec),
        .route_i   (route_vec),
        .line_en_i (line_en_vec),
        .irq_o     (irq_vec)
    );

    // Read mux: flags are returned raw, never masked.
    always_comb begin
        case (addr_sel)
            REG_FLAG:    reg_rdata_o = flag_vec;
            REG_ENABLE:  reg_rdata_o = enable_vec;
            REG_ROUTE:   reg_rdata_o = route_vec;
            default:     reg_rdata_o = {{PAD_W{1'b0}}, line_en_vec};
        endcase
    end

    assign irq_line0_o = irq_vec[0];
    assign irq_line1_o = irq_vec[1];

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] event_i,
    input logic         reg_wr_i,
    input logic [1:0]   reg_addr_i,
    input logic [N-1:0] reg_wdata_i,
    input logic [N-1:0] flag_vec,
    input logic [1:0]   line_en_vec,
    input logic         irq_line0_o,
    input logic         irq_line1_o
);

    // Independent event history, reset to zero like the requirement states.
    logic [N-1:0] ev_hist_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_hist_q <= '0;
        else        ev_hist_q <= event_i;
    end

    logic [N-1:0] rose_c;
    logic [N-1:0] wclr_c;
    assign rose_c = event_i & ~ev_hist_q;
    assign wclr_c = (reg_wr_i && reg_addr_i == 2'd0) ? reg_wdata_i : '0;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // R2 and R5: an edge always leaves the flag set, clear or not.
        p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            rose_c[i] |=> flag_vec[i]);
        // R2: no edge on a clear flag keeps it clear.
        p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_vec[i] && !rose_c[i]) |=> !flag_vec[i]);
        // R3: sticky without a clear.
        p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_vec[i] && !wclr_c[i]) |=> flag_vec[i]);
        // R4: write-one-clear without competing edge.
        p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wclr_c[i] && !rose_c[i]) |=> !flag_vec[i]);
    end

    // R8: a closed gate keeps its line low.
    p_gate0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en_vec[0] |-> !irq_line0_o);
    p_gate1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en_vec[1] |-> !irq_line1_o);
    // R11: no line without a pending flag.
    p_line_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_line0_o || irq_line1_o) |-> (flag_vec != '0));

endmodule

bind irq_router irq_router_chk #(.N(N_FLAGS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .event_i     (event_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .flag_vec    (flag_vec),
    .line_en_vec (line_en_vec),
    .irq_line0_o (irq_line0_o),
    .irq_line1_o (irq_line1_o)
);

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] event_i = '0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq0, irq1;

    always #2.5 clk = ~clk;

    irq_router #(.N_FLAGS(N)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .event_i     (event_i),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_line0_o (irq0),
        .irq_line1_o (irq1)
    );

    typedef struct {
        string        tag;
        logic [1:0]   addr;
        logic [N-1:0] data;
        logic         l0;
        logic         l1;
    } exp_t;

    exp_t exp_q[$];
    int   errors = 0;
    int   checks = 0;
    bit   done = 0;

    // Reference model from the requirements.
    logic [N-1:0] flags_m = '0, en_m = '0, route_m = '0, ev_prev_m = '0;
    logic [1:0]   gate_m = '0;

    task automatic cyc(input logic [N-1:0] ev, input logic wr,
                       input logic [1:0] a, input logic [N-1:0] wd);
        logic [N-1:0] rise;
        @(negedge clk);
        event_i = ev; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        rise = ev & ~ev_prev_m;
        if (wr && a == 2'd0) flags_m = (flags_m & ~wd) | rise;
        else                 flags_m = flags_m | rise;
        if (wr) begin
            case (a)
                2'd1: en_m = wd;
                2'd2: route_m = wd;
                2'd3: gate_m = wd[1:0];
                default: ;
            endcase
        end
        ev_prev_m = ev;
    endtask

    // Idle read cycle; expectation is compared just after the next edge.
    task automatic chk(input string tag, input logic [1:0] a);
        exp_t e;
        cyc(ev_prev_m, 1'b0, a, '0);
        e.tag  = tag;
        e.addr = a;
        case (a)
            2'd0: e.data = flags_m;
            2'd1: e.data = en_m;
            2'd2: e.data = route_m;
            default: e.data = {{(N-2){1'b0}}, gate_m};
        endcase
        e.l0 = gate_m[0] & |(flags_m & en_m & ~route_m);
        e.l1 = gate_m[1] & |(flags_m & en_m & route_m);
        exp_q.push_back(e);
    endtask

    // Monitor: pops expectations and compares away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (reg_rdata !== e.data || irq0 !== e.l0 || irq1 !== e.l1) begin
                    errors++;
                    $display("FAIL %s addr=%0d actual data=%h l0=%b l1=%b expected data=%h l0=%b l1=%b",
                             e.tag, e.addr, reg_rdata, irq0, irq1, e.data, e.l0, e.l1);
                end
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and both lines
        for (int a = 0; a < 4; a++) chk("R1 reset", 2'(a));

        // R2: single pulse sets a flag; disabled flag gives no line (R6)
        cyc(16'h0008, 0, 0, '0);
        cyc(16'h0000, 0, 0, '0);
        chk("R2 pulse sets flag", 0);
        chk("R6 disabled flag keeps lines low", 0);

        // R2: held level does not reset flag after clear
        cyc(16'h0020, 0, 0, '0);
        cyc(16'h0020, 0, 0, '0);
        cyc(16'h0020, 1, 0, 16'h0020);
        cyc(16'h0020, 0, 0, '0);
        chk("R2 held level no re-set", 0);
        cyc(16'h0000, 0, 0, '0);

        // R4: writing zeros has no effect, writing one clears
        cyc(16'h0000, 1, 0, 16'h0000);
        chk("R4 write zero no effect", 0);
        cyc(16'h0000, 1, 0, 16'h0008);
        chk("R4 write one clears", 0);

        // R3: flag holds across idle cycles
        cyc(16'h0100, 0, 0, '0);
        cyc(16'h0000, 0, 0, '0);
        repeat (10) cyc(16'h0000, 0, 0, '0);
        chk("R3 flag sticky", 0);

        // R5: edge and clear on same bit in same cycle
        cyc(16'h0080, 1, 0, 16'h0180);
        chk("R5 set wins over clear", 0);
        cyc(16'h0000, 0, 0, '0);

        // R6, R7, R8, R11: routing and gating
        cyc(16'h0000, 1, 1, 16'h0080);
        cyc(16'h0000, 1, 3, 16'hFFFF);
        chk("R8 gate readback upper zero", 3);
        chk("R7 route 0 to line0", 0);
        cyc(16'h0000, 1, 2, 16'h0080);
        chk("R7 route 1 to line1", 0);
        cyc(16'h0000, 1, 3, 16'h0001);
        chk("R8 gate1 closed", 0);
        cyc(16'h0000, 1, 3, 16'h0002);
        chk("R8 gate1 open", 0);
        cyc(16'h0000, 1, 1, 16'h0100);
        chk("R11 other flag enabled on line0", 0);
        cyc(16'h0000, 1, 1, 16'h0000);
        chk("R9 raw flags with all disabled", 0);

        // R10: register readback and isolation
        cyc(16'h0000, 1, 1, 16'hA5C3);
        cyc(16'h0000, 1, 2, 16'h3C5A);
        chk("R10 enable readback", 1);
        chk("R10 route readback", 2);

        // Pseudo-random mix (R6, R9, R11)
        lfsr = 32'hACE1_2345;
        for (int it = 0; it < 60; it++) begin
            for (int k = 0; k < 3; k++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                cyc(lfsr[15:0] & lfsr[31:16], lfsr[3] & lfsr[9],
                    lfsr[5:4], lfsr[27:12]);
            end
            chk("R11 random mix", 2'(it % 4));
        end

        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule